// File: doc/BRIEF.md
# Multi-Source System Reset Generator

This block turns three reset causes into the reset and interrupt lines a processor subsystem needs. A power-good input is stretched into a long processor hard reset. A debounced reset button first raises a warning interrupt to the processor, so that the operating system can quiet audio and video. After a long programmable delay it then issues a processor soft reset that is held for a fixed minimum number of clocks. Software can also request the same stretched soft reset through a register-write strobe, without raising the interrupt and without the warning delay.

An active-low system reset is asserted whenever either the hard reset or the soft reset is active. An active-low IO-bus reset is forced low whenever system reset is low and stays low afterwards until software writes a release value. While system reset is inactive, the IO-bus reset simply follows software writes. All counts are parameters in clock cycles, so that simulation can use short values.

Top module: `sys_reset_gen`

## Requirements
- R1: While `pwr_ok` is low, `cpu_hard_rst` is high. After `pwr_ok` rises it stays high until the `POR_CYCLES`-th rising clock edge, at which it falls.
- R2: `sys_rst_n` is low exactly while `cpu_hard_rst` or `cpu_soft_rst` is high, and is high otherwise.
- R3: A rising edge on `btn_press`, sampled at a clock edge while no reset sequence is running, drives `cpu_int2` high after that same edge.
- R4: After a button edge, `cpu_soft_rst` rises `BTN_DELAY_CYCLES` clock edges after `cpu_int2` rises.
- R5: Every soft reset keeps `cpu_soft_rst` high for exactly `STRETCH_CYCLES` clocks, a value of at least 64.
- R6: A one-cycle `sw_soft_req` pulse in the idle state drives `cpu_soft_rst` high after the next clock edge, with no delay, and leaves `cpu_int2` unchanged.
- R7: A button edge or software request that arrives while a delay or stretch is running, or while the hard reset is active, is ignored and produces no further soft reset.
- R8: `cpu_int2` stays high until a `sw_int2_clr` pulse clears it or until the soft reset begins, whichever comes first. A clear does not cancel the pending soft reset.
- R9: `io_rst_n` is low whenever `sys_rst_n` is low. Writes made during that time are ignored, and `io_rst_n` is still low after `sys_rst_n` returns high.
- R10: While `sys_rst_n` is high, a `sw_io_wr` pulse sets `io_rst_n` to `sw_io_val` after the next clock edge (1 releases the IO-bus reset, 0 asserts it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| pwr_ok | input | 1 | Power-good, active high; low resets the block asynchronously |
| btn_press | input | 1 | Debounced reset button level, high when pressed |
| sw_soft_req | input | 1 | Software soft-reset request strobe |
| sw_int2_clr | input | 1 | Software strobe clearing the warning interrupt |
| sw_io_wr | input | 1 | Software write strobe for the IO-bus reset |
| sw_io_val | input | 1 | Value written with `sw_io_wr` (1 = release) |
| cpu_hard_rst | output | 1 | Processor hard reset, active high |
| cpu_soft_rst | output | 1 | Processor soft reset, active high |
| cpu_int2 | output | 1 | Button warning interrupt to the processor |
| sys_rst_n | output | 1 | System reset, active low |
| io_rst_n | output | 1 | IO-bus reset, active low |

## Verification
The bench presses the button a second time in the middle of the delay window and issues a software request in the middle of a stretch. A design that restarted its counters on these events would lengthen the gap or fire a second soft reset. It clears the interrupt during the delay, which catches a design that cancels the pending reset or forgets to clear the line. It also makes IO-bus release writes during a soft reset, which catches a design that lets software lift the IO-bus reset early. Finally, it checks that a software request made during power-on reset is ignored, and that software requests never raise the interrupt.

// File: rtl/sys_reset_gen.sv
module sys_reset_gen #(
  parameter int POR_CYCLES       = 5_000_000,
  parameter int BTN_DELAY_CYCLES = 25_000_000,
  parameter int STRETCH_CYCLES   = 64
) (
  input  logic clk,
  input  logic pwr_ok,
  input  logic btn_press,
  input  logic sw_soft_req,
  input  logic sw_int2_clr,
  input  logic sw_io_wr,
  input  logic sw_io_val,
  output logic cpu_hard_rst,
  output logic cpu_soft_rst,
  output logic cpu_int2,
  output logic sys_rst_n,
  output logic io_rst_n
);
  localparam int MAXC = (BTN_DELAY_CYCLES > STRETCH_CYCLES) ? BTN_DELAY_CYCLES : STRETCH_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int PW   = $clog2(POR_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HOLD} st_t;

  logic          por_act;
  logic [PW-1:0] por_cnt;
  logic          btn_q;
  st_t           st;
  logic [CW-1:0] cnt;
  logic          int2_q;
  logic          io_q;

  wire btn_rise = btn_press & ~btn_q;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      por_act <= 1'b1;
      por_cnt <= '0;
    end else if (por_act) begin
      if (por_cnt == PW'(POR_CYCLES - 1)) por_act <= 1'b0;
      else                                 por_cnt <= por_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) btn_q <= 1'b0;
    else         btn_q <= btn_press;
  end

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      st     <= S_IDLE;
      cnt    <= '0;
      int2_q <= 1'b0;
    end else begin
      if (sw_int2_clr) int2_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (!por_act) begin
            if (btn_rise) begin
              st     <= S_WAIT;
              cnt    <= '0;
              int2_q <= 1'b1;
            end else if (sw_soft_req) begin
              st  <= S_HOLD;
              cnt <= '0;
            end
          end
        end
        S_WAIT: begin
          if (cnt == CW'(BTN_DELAY_CYCLES - 1)) begin
            st     <= S_HOLD;
            cnt    <= '0;
            int2_q <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (cnt == CW'(STRETCH_CYCLES - 1)) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok)        io_q <= 1'b0;
    else if (!sys_rst_n) io_q <= 1'b0;
    else if (sw_io_wr)  io_q <= sw_io_val;
  end

  assign cpu_hard_rst = por_act;
  assign cpu_soft_rst = (st == S_HOLD);
  assign cpu_int2     = int2_q;
  assign sys_rst_n    = ~(por_act | cpu_soft_rst);
  assign io_rst_n     = io_q & sys_rst_n;
endmodule

// File: rtl/sys_reset_gen_chk.sv
module sys_reset_gen_chk #(
  parameter int STRETCH_CYCLES = 64
) (
  input logic clk,
  input logic pwr_ok,
  input logic sw_int2_clr,
  input logic cpu_hard_rst,
  input logic cpu_soft_rst,
  input logic cpu_int2,
  input logic sys_rst_n,
  input logic io_rst_n
);
  localparam int RW = $clog2(STRETCH_CYCLES + 1);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok)           run <= '0;
    else if (cpu_soft_rst) run <= (run == RW'(STRETCH_CYCLES)) ? run : run + 1'b1;
    else                   run <= '0;
  end

  assert_stretch_bound_R5: assert property (@(posedge clk) disable iff (!pwr_ok)
    cpu_soft_rst |-> (run < RW'(STRETCH_CYCLES)));

  assert_stretch_full_R5: assert property (@(posedge clk) disable iff (!pwr_ok)
    $fell(cpu_soft_rst) |-> ($past(run) == RW'(STRETCH_CYCLES - 1)));

  assert_io_follows_sys_R9: assert property (@(posedge clk) disable iff (!pwr_ok)
    !sys_rst_n |-> !io_rst_n);

  assert_no_soft_in_hard_R7: assert property (@(posedge clk) disable iff (!pwr_ok)
    cpu_hard_rst |-> !cpu_soft_rst);

  assert_int2_release_R8: assert property (@(posedge clk) disable iff (!pwr_ok)
    $fell(cpu_int2) |-> ($past(sw_int2_clr) || cpu_soft_rst));

  assert_sys_after_por_R2: assert property (@(posedge clk) disable iff (!pwr_ok)
    $fell(cpu_hard_rst) |-> sys_rst_n);
endmodule

bind sys_reset_gen sys_reset_gen_chk #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chk (
  .clk(clk), .pwr_ok(pwr_ok), .sw_int2_clr(sw_int2_clr),
  .cpu_hard_rst(cpu_hard_rst), .cpu_soft_rst(cpu_soft_rst), .cpu_int2(cpu_int2),
  .sys_rst_n(sys_rst_n), .io_rst_n(io_rst_n)
);

// File: tb/tb_sys_reset_gen.sv
module tb_sys_reset_gen;
  localparam int POR  = 10;
  localparam int BDLY = 30;
  localparam int STR  = 64;
  localparam int NSC  = 4;
  localparam int SC_BTN[NSC] = '{1, 0, 1, 0};
  localparam int SC_INT[NSC] = '{1, 0, 1, 0};
  localparam int SC_GAP[NSC] = '{BDLY + 1, 1, BDLY + 1, 1};

  logic clk = 1'b0;
  logic pwr_ok = 1'b0, btn_press = 1'b0, sw_soft_req = 1'b0, sw_int2_clr = 1'b0;
  logic sw_io_wr = 1'b0, sw_io_val = 1'b0;
  logic cpu_hard_rst, cpu_soft_rst, cpu_int2, sys_rst_n, io_rst_n;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sys_reset_gen #(.POR_CYCLES(POR), .BTN_DELAY_CYCLES(BDLY), .STRETCH_CYCLES(STR)) dut (
    .clk(clk), .pwr_ok(pwr_ok), .btn_press(btn_press), .sw_soft_req(sw_soft_req),
    .sw_int2_clr(sw_int2_clr), .sw_io_wr(sw_io_wr), .sw_io_val(sw_io_val),
    .cpu_hard_rst(cpu_hard_rst), .cpu_soft_rst(cpu_soft_rst), .cpu_int2(cpu_int2),
    .sys_rst_n(sys_rst_n), .io_rst_n(io_rst_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic io_write(input logic v);
    @(negedge clk); sw_io_wr = 1'b1; sw_io_val = v;
    @(negedge clk); sw_io_wr = 1'b0;
  endtask

  task automatic run_req(input bit is_btn, output int gap, output int len,
                         output int int_seen, output int sys_low);
    @(negedge clk);
    if (is_btn) btn_press = 1'b1; else sw_soft_req = 1'b1;
    @(negedge clk);
    sw_soft_req = 1'b0;
    int_seen = cpu_int2;
    gap = 1;
    while (!cpu_soft_rst && gap < 5000) begin @(negedge clk); gap++; end
    sys_low = !sys_rst_n;
    len = 0;
    while (cpu_soft_rst && len < 5000) begin
      len++;
      sw_io_wr = (len == 5); sw_io_val = 1'b1;
      @(negedge clk);
    end
    sw_io_wr = 1'b0;
    btn_press = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int gap, len, iseen, slow, n;
    repeat (3) @(negedge clk);
    chk("R1 hard in reset", cpu_hard_rst, 1);
    chk("R2 sys in reset", sys_rst_n, 0);
    chk("R9 io in reset", io_rst_n, 0);
    chk("R3 int2 in reset", cpu_int2, 0);

    pwr_ok = 1'b1;
    n = 0;
    @(negedge clk);
    while (cpu_hard_rst && n < 1000) begin
      n++;
      sw_soft_req = (n == 2);
      @(negedge clk);
    end
    sw_soft_req = 1'b0;
    chk("R1 hard length", n, POR - 1);
    chk("R7 sw req in hard ignored", cpu_soft_rst, 0);
    chk("R2 sys released", sys_rst_n, 1);
    chk("R9 io held after por", io_rst_n, 0);
    io_write(1'b1);
    chk("R10 io release", io_rst_n, 1);

    for (int i = 0; i < NSC; i++) begin
      run_req(SC_BTN[i] != 0, gap, len, iseen, slow);
      chk(SC_BTN[i] != 0 ? "R3 int2 on press" : "R6 int2 untouched", iseen, SC_INT[i]);
      chk(SC_BTN[i] != 0 ? "R4 delay" : "R6 immediate", gap, SC_GAP[i]);
      chk("R5 stretch length", len, STR);
      chk("R2 sys low in soft", slow, 1);
      chk("R8 int2 gone after soft", cpu_int2, 0);
      chk("R9 io held after soft", io_rst_n, 0);
      io_write(1'b1);
      chk("R10 io release", io_rst_n, 1);
    end

    @(negedge clk); btn_press = 1'b1;
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    btn_press = 1'b0;
    @(negedge clk); n++;
    btn_press = 1'b1;
    while (!cpu_soft_rst && n < 5000) begin @(negedge clk); n++; end
    chk("R7 second press ignored", n, BDLY + 1);
    len = 0;
    while (cpu_soft_rst && len < 5000) begin
      len++;
      sw_soft_req = (len == 10);
      @(negedge clk);
    end
    sw_soft_req = 1'b0;
    chk("R7 sw during stretch ignored", len, STR);
    n = 0;
    repeat (BDLY + STR + 10) begin @(negedge clk); if (cpu_soft_rst) n++; end
    chk("R7 no follow-up soft", n, 0);
    btn_press = 1'b0;
    io_write(1'b1);

    @(negedge clk); btn_press = 1'b1;
    @(negedge clk); n = 1;
    chk("R3 int2 raised", cpu_int2, 1);
    @(negedge clk); n++; sw_int2_clr = 1'b1;
    @(negedge clk); n++; sw_int2_clr = 1'b0;
    chk("R8 int2 cleared by sw", cpu_int2, 0);
    while (!cpu_soft_rst && n < 5000) begin @(negedge clk); n++; end
    chk("R8 clear keeps pending soft", n, BDLY + 1);
    while (cpu_soft_rst) @(negedge clk);
    btn_press = 1'b0;

    io_write(1'b1);
    chk("R10 io write one", io_rst_n, 1);
    io_write(1'b0);
    chk("R10 io write zero", io_rst_n, 0);
    io_write(1'b1);
    chk("R10 io write one again", io_rst_n, 1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule